// File: doc/BRIEF.md
# Display List Instruction Processor

This block is a memory-to-display transfer channel that walks a list of words in memory and hands them one at a time to a display. A pointer register (the fetch pointer) names the next word to read; after every fetch it moves forward by one. Most words are plain data and go straight to the display. A word whose most significant bit is set is an instruction instead. The channel decodes the three lowest bits of such a word and either ends the list, jumps elsewhere, or makes a subroutine call that leaves a return address in memory. This lets a display program be built from pieces scattered through memory.

Software starts the channel by presenting a start address with a load strobe. The display then asks for words by holding its request line high, and each fetched data word comes back as a one-cycle valid pulse. Memory is reached over a single request/acknowledge port that reads and writes whole words. While an instruction is being carried out, the display request and the load strobe are both ignored, and the instruction always finishes.

Top module: `dlp_top`

## Requirements
- R1: After reset, `busy`, `mem_req` and `disp_valid` are low.
- R2: A `load_req` pulse while idle sets the fetch pointer to `load_addr` and raises `busy`. A word is fetched only while `disp_req` is high. Each data word (MSB = 0) is emitted once, with a one-cycle `disp_valid` pulse and `disp_last` low, and the pointer then moves to the next address.
- R3: A word with MSB = 1 is an instruction, and its bits [2:0] choose the operation: 3'b001 stop, 3'b010 branch, 3'b011 call. Every other code is a no-operation. A no-operation word is not sent to the display, and fetching goes on at the next address.
- R4: A stop word is sent to the display with `disp_last` high. In the same cycle `busy` falls, and no further memory request is made.
- R5: Branch reads the word that follows it as an address word, whose bits [AW-1:0] give the target. Fetching resumes at the target.
- R6: An address word with MSB = 1 is indirect. Its bits [AW-1:0] point to another address word, and this repeats until an address word with MSB = 0 is read.
- R7: Call resolves its target as in R5 and R6. It then writes the address of the word after its first address word into the target location (with MSB = 0), and fetching resumes at target + 1.
- R8: Between the fetch of an instruction word and the end of its execution, `load_req` and `disp_req` have no effect, and the instruction completes.
- R9: A `load_req` while busy and not executing an instruction moves the fetch pointer to `load_addr`.
- R10: Once `mem_req` is raised, it stays high with `mem_addr` and `mem_we` unchanged until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_req | input | 1 | Load fetch pointer strobe |
| load_addr | input | AW | Start address for the load |
| disp_req | input | 1 | Display wants a word (level) |
| disp_valid | output | 1 | One-cycle pulse: disp_data holds a word |
| disp_data | output | W | Word delivered to the display |
| disp_last | output | 1 | Delivered word is a stop instruction |
| busy | output | 1 | Channel is running a list |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | W | Write data |
| mem_ack | input | 1 | Access done; read data valid this cycle |
| mem_rdata | input | W | Read data |

## Verification
The hardest case to reach from the ports is a load strobe or a dropped display request that lands while an instruction is still running, because that window lasts only as long as the address-word memory accesses. The bench's memory model has an adjustable acknowledge latency. The bench stretches the latency, watches `mem_addr` for the address-word fetch, and asserts `load_req` while lowering `disp_req` inside that window. It then checks that the first word delivered afterwards comes from the branch target. Indirect chains and the word written by a call are checked by reading the model's memory after the run.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
  localparam int OPC_W = 3;
  localparam logic [OPC_W-1:0] OPC_STOP   = 3'b001;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 3'b010;
  localparam logic [OPC_W-1:0] OPC_CALL   = 3'b011;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_FETCH,
    ST_ADDR,
    ST_STORE
  } dlp_state_e;

  typedef enum logic [1:0] {
    INS_NOP,
    INS_STOP,
    INS_BRANCH,
    INS_CALL
  } dlp_ins_e;
endpackage

// File: rtl/dlp_decode.sv
module dlp_decode
  import dlp_pkg::*;
(
  input  logic             flag,
  input  logic [OPC_W-1:0] opc,
  output logic             is_instr,
  output dlp_ins_e         ins
);
  assign is_instr = flag;

  always_comb begin
    case (opc)
      OPC_STOP:   ins = INS_STOP;
      OPC_BRANCH: ins = INS_BRANCH;
      OPC_CALL:   ins = INS_CALL;
      default:    ins = INS_NOP;
    endcase
  end
endmodule

// File: rtl/dlp_cwa.sv
module dlp_cwa #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] cwa
);
  always_ff @(posedge clk) begin
    if (rst)       cwa <= '0;
    else if (load) cwa <= load_val;
    else if (inc)  cwa <= cwa + AW'(1);
  end
endmodule

// File: rtl/dlp_ctrl.sv
module dlp_ctrl
  import dlp_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_req,
  input  logic [AW-1:0] load_addr,
  input  logic          disp_req,
  input  logic          mem_ack,
  input  logic [W-1:0]  mem_rdata,
  input  logic          word_is_instr,
  input  dlp_ins_e      word_ins,
  input  logic [AW-1:0] cwa,
  output logic          cwa_load,
  output logic [AW-1:0] cwa_load_val,
  output logic          cwa_inc,
  output logic          disp_valid,
  output logic [W-1:0]  disp_data,
  output logic          disp_last,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata
);
  localparam int PADW = W - AW;

  dlp_state_e    state;
  logic          is_call;
  logic [AW-1:0] ret_q;
  logic [AW-1:0] tgt_q;
  logic          ind_bit;
  logic [AW-1:0] target;

  assign ind_bit = mem_rdata[W-1];
  assign target  = mem_rdata[AW-1:0];

  always_comb begin
    cwa_load     = 1'b0;
    cwa_load_val = load_addr;
    cwa_inc      = 1'b0;
    case (state)
      ST_IDLE, ST_RUN: cwa_load = load_req;
      ST_FETCH:        cwa_inc  = mem_ack;
      ST_ADDR: begin
        if (mem_ack && !ind_bit && !is_call) begin
          cwa_load     = 1'b1;
          cwa_load_val = target;
        end
      end
      ST_STORE: begin
        if (mem_ack) begin
          cwa_load     = 1'b1;
          cwa_load_val = tgt_q + AW'(1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      is_call    <= 1'b0;
      ret_q      <= '0;
      tgt_q      <= '0;
      disp_valid <= 1'b0;
      disp_data  <= '0;
      disp_last  <= 1'b0;
      busy       <= 1'b0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      disp_valid <= 1'b0;
      disp_last  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (load_req) begin
            busy  <= 1'b1;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (!load_req && disp_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= cwa;
            state    <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            if (!word_is_instr) begin
              mem_req    <= 1'b0;
              disp_valid <= 1'b1;
              disp_data  <= mem_rdata;
              state      <= ST_RUN;
            end else begin
              case (word_ins)
                INS_STOP: begin
                  mem_req    <= 1'b0;
                  disp_valid <= 1'b1;
                  disp_last  <= 1'b1;
                  disp_data  <= mem_rdata;
                  busy       <= 1'b0;
                  state      <= ST_IDLE;
                end
                INS_BRANCH, INS_CALL: begin
                  is_call  <= (word_ins == INS_CALL);
                  ret_q    <= cwa + AW'(2);
                  mem_addr <= cwa + AW'(1);
                  state    <= ST_ADDR;
                end
                default: begin
                  mem_req <= 1'b0;
                  state   <= ST_RUN;
                end
              endcase
            end
          end
        end
        ST_ADDR: begin
          if (mem_ack) begin
            if (ind_bit) begin
              mem_addr <= target;
            end else if (is_call) begin
              mem_we    <= 1'b1;
              mem_addr  <= target;
              mem_wdata <= {{PADW{1'b0}}, ret_q};
              tgt_q     <= target;
              state     <= ST_STORE;
            end else begin
              mem_req <= 1'b0;
              state   <= ST_RUN;
            end
          end
        end
        ST_STORE: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            state   <= ST_RUN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    disp_valid |=> !disp_valid); // R2
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
    disp_last |-> (!busy && disp_valid)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R4
  AST_RET_PLAIN: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> !mem_wdata[W-1]); // R7
  AST_LOAD_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_ADDR || state == ST_STORE) && load_req && !mem_ack) |=> $stable(cwa)); // R8
endmodule

// File: rtl/dlp_top.sv
module dlp_top
  import dlp_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_req,
  input  logic [AW-1:0] load_addr,
  input  logic          disp_req,
  output logic          disp_valid,
  output logic [W-1:0]  disp_data,
  output logic          disp_last,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic          mem_ack,
  input  logic [W-1:0]  mem_rdata
);
  logic          word_is_instr;
  dlp_ins_e      word_ins;
  logic [AW-1:0] cwa;
  logic          cwa_load;
  logic [AW-1:0] cwa_load_val;
  logic          cwa_inc;

  dlp_decode u_dec (
    .flag     (mem_rdata[W-1]),
    .opc      (mem_rdata[OPC_W-1:0]),
    .is_instr (word_is_instr),
    .ins      (word_ins)
  );

  dlp_cwa #(.AW(AW)) u_cwa (
    .clk      (clk),
    .rst      (rst),
    .load     (cwa_load),
    .load_val (cwa_load_val),
    .inc      (cwa_inc),
    .cwa      (cwa)
  );

  dlp_ctrl #(.W(W), .AW(AW)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .load_req      (load_req),
    .load_addr     (load_addr),
    .disp_req      (disp_req),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .word_is_instr (word_is_instr),
    .word_ins      (word_ins),
    .cwa           (cwa),
    .cwa_load      (cwa_load),
    .cwa_load_val  (cwa_load_val),
    .cwa_inc       (cwa_inc),
    .disp_valid    (disp_valid),
    .disp_data     (disp_data),
    .disp_last     (disp_last),
    .busy          (busy),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata)
  );
endmodule

// File: tb/sim_dlp_top.sv
module sim_dlp_top;
  localparam int CLK_P = 10;
  localparam int W = 16;
  localparam int AW = 15;
  localparam int NV = 10;
  // fields: sel[54:51] n[50:49] w0[48:33] w1[32:17] w2[16:1] last_on_w1[0]
  localparam logic [54:0] VEC [NV] = '{
    {4'd0, 2'd3, 16'h0111, 16'h0030, 16'h0222, 1'b0},
    {4'd1, 2'd2, 16'h0111, 16'h8001, 16'h0000, 1'b1},
    {4'd2, 2'd3, 16'h0111, 16'h0333, 16'h0444, 1'b0},
    {4'd3, 2'd3, 16'h0111, 16'h0444, 16'h0555, 1'b0},
    {4'd4, 2'd3, 16'h0111, 16'h0030, 16'h0222, 1'b0},
    {4'd5, 2'd3, 16'h0111, 16'h0030, 16'h0222, 1'b0},
    {4'd6, 2'd3, 16'h0111, 16'h0030, 16'h0222, 1'b0},
    {4'd7, 2'd3, 16'h0111, 16'h0030, 16'h0222, 1'b0},
    {4'd8, 2'd2, 16'h0666, 16'h0777, 16'h0000, 1'b0},
    {4'd9, 2'd1, 16'h0888, 16'h0000, 16'h0000, 1'b0}
  };

  logic clk = 0;
  logic rst = 1;
  logic load_req = 0;
  logic [AW-1:0] load_addr = '0;
  logic disp_req = 0;
  logic disp_valid, disp_last, busy, mem_req, mem_we, mem_ack;
  logic [W-1:0] disp_data, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  logic [W-1:0] mem [64];
  logic [3:0] img_sel = '0;
  logic img_go = 0;
  int lat_v = 0;
  int cnt;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  dlp_top #(.W(W), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .load_req(load_req), .load_addr(load_addr),
    .disp_req(disp_req), .disp_valid(disp_valid), .disp_data(disp_data),
    .disp_last(disp_last), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (img_go) begin
      for (int i = 0; i < 64; i++) mem[i] <= '0;
      case (img_sel)
        4'd8: begin
          mem[16] <= 16'h8002; mem[17] <= 16'h8020; mem[32] <= 16'h8021;
          mem[33] <= 16'h0038; mem[56] <= 16'h0666; mem[57] <= 16'h0777;
        end
        4'd9: begin
          mem[16] <= 16'h8003; mem[17] <= 16'h8020; mem[32] <= 16'h0038;
          mem[57] <= 16'h0888;
        end
        4'd10: begin
          mem[16] <= 16'h8002; mem[17] <= 16'h0030; mem[48] <= 16'h0333;
          mem[8]  <= 16'h0999;
        end
        default: begin
          mem[16] <= 16'h0111; mem[17] <= {13'h1000, img_sel[2:0]};
          mem[18] <= 16'h0030; mem[19] <= 16'h0222; mem[48] <= 16'h0333;
          mem[49] <= 16'h0444; mem[50] <= 16'h0555;
        end
      endcase
    end
    if (rst) begin
      cnt <= 0;
    end else if (mem_req && !mem_ack) begin
      if (cnt >= lat_v) begin
        cnt <= 0;
        mem_ack <= 1'b1;
        mem_rdata <= mem[mem_addr[5:0]];
        if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] sel, input int lat);
    @(negedge clk);
    rst = 1; load_req = 0; disp_req = 0;
    img_sel = sel; lat_v = lat; img_go = 1;
    @(negedge clk);
    img_go = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic pulse_load(input logic [AW-1:0] a);
    load_addr = a; load_req = 1;
    @(negedge clk);
    load_req = 0;
  endtask

  task automatic get_word(output logic [W-1:0] d, output logic l, output bit ok);
    ok = 0; d = '0; l = 0;
    for (int t = 0; t < 300; t++) begin
      @(negedge clk);
      if (disp_valid) begin
        d = disp_data; l = disp_last; ok = 1;
        break;
      end
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (done) break;
      if ($time > 150000 * CLK_P) begin
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] d;
    logic l;
    bit ok;
    int seen;

    // R1 reset state
    do_reset(4'd0, 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 disp_valid", 32'(disp_valid), 0);

    // table walk: R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      logic [54:0] e;
      logic [W-1:0] ew;
      e = VEC[v];
      do_reset(e[54:51], v % 3);
      pulse_load(AW'(16));
      disp_req = 1;
      for (int k = 0; k < int'(e[50:49]); k++) begin
        ew = (k == 0) ? e[48:33] : (k == 1) ? e[32:17] : e[16:1];
        get_word(d, l, ok);
        chk("R3 R5 R6 word present", 32'(ok), 1);
        chk("R3 R5 R6 R7 word value", 32'(d), 32'(ew));
        chk("R4 last flag", 32'(l), 32'((k == 1) && e[0]));
      end
      if (e[54:51] == 4'd1) begin
        chk("R4 busy after stop", 32'(busy), 0);
        seen = 0;
        repeat (10) begin @(negedge clk); if (mem_req) seen++; end
        chk("R4 no fetch after stop", 32'(seen), 0);
      end
      if (e[54:51] == 4'd3) chk("R7 return address stored", 32'(mem[48]), 32'h0013);
      if (e[54:51] == 4'd9) chk("R7 R6 return address via indirect", 32'(mem[56]), 32'h0012);
      disp_req = 0;
    end

    // R2 fetch gated by disp_req, one word per request window
    do_reset(4'd0, 1);
    pulse_load(AW'(16));
    seen = 0;
    repeat (10) begin @(negedge clk); if (mem_req) seen++; end
    chk("R2 no fetch without disp_req", 32'(seen), 0);
    chk("R2 busy after load", 32'(busy), 1);
    disp_req = 1;
    get_word(d, l, ok);
    disp_req = 0;
    chk("R2 first word", 32'(d), 32'h0111);
    seen = 0;
    repeat (10) begin @(negedge clk); if (disp_valid) seen++; end
    chk("R2 nothing while disp_req low", 32'(seen), 0);
    disp_req = 1;
    get_word(d, l, ok);
    disp_req = 0;
    chk("R2 R3 next word after nop code 0", 32'(d), 32'h0030);

    // R8 lockout during branch execution, then R9 reload while running
    do_reset(4'd10, 4);
    pulse_load(AW'(16));
    disp_req = 1;
    seen = 0;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (mem_req && mem_addr == AW'(17)) begin seen = 1; break; end
    end
    chk("R8 address word fetch reached", 32'(seen), 1);
    disp_req = 0;
    load_addr = AW'(8); load_req = 1;
    repeat (3) @(negedge clk);
    load_req = 0;
    repeat (20) @(negedge clk);
    chk("R8 still busy", 32'(busy), 1);
    disp_req = 1;
    get_word(d, l, ok);
    disp_req = 0;
    chk("R8 branch completed despite load", 32'(d), 32'h0333);
    repeat (3) @(negedge clk);
    pulse_load(AW'(8));
    disp_req = 1;
    get_word(d, l, ok);
    disp_req = 0;
    chk("R9 reload while running", 32'(d), 32'h0999);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule